// File: doc/BRIEF.md
# Coarse Complex Mixer with Per-Path DC Offset

The block accepts one sample stream in which in-phase and quadrature words alternate. It gathers each pair into an A word (the first sample) and a B word (the second sample). It then turns the pair through a coarse angle that steps by a quarter turn, a half turn or nothing per pair. The two results form a Hilbert pair: A·cos − B·sin on path A and A·sin + B·cos on path B. A signed offset of its own is then added to each path, so that downstream carrier leakage can be trimmed out. Each sum saturates to the 16-bit range.

The coarse frequency is limited to zero, +fs/4, −fs/4 and fs/2. Sine and cosine therefore only take the values 0 and ±1, and the rotation reduces to swapping and negating words. A sideband control reverses the direction of rotation, which turns an upper-sideband plan into a lower-sideband plan. With the frequency set to zero the pair passes through unrotated, which is the zero-IF case.

Two small state machines carry the behaviour. The splitter has two states, ST_TAKE_I and ST_TAKE_Q:
- A valid sample in ST_TAKE_I is held, and the machine moves to ST_TAKE_Q.
- A valid sample in ST_TAKE_Q completes a pair, and the machine returns to ST_TAKE_I.
- A cycle without a valid sample keeps the current state.

The phase machine has four states, PH_0, PH_90, PH_180 and PH_270:
- Each pair moves it forward by the selected step.
- Any change of frequency or sideband sends it back to PH_0.

Top module: `cplx_mixer_ofs`

## Requirements
- R1: After reset, the first valid input sample is the A word of a pair and the next valid sample is its B word. Cycles with `in_valid` low are ignored and do not break a pair.
- R2: `out_valid` is high for exactly one cycle per pair. It is high in the second cycle after the cycle in which the B word was presented, and low at all other times.
- R3: `freq_sel` encoding: 0 = no rotation, 1 = +fs/4, 2 = fs/2, 3 = −fs/4. These give phase steps per pair of 0, 1, 2 and 3 quarter turns.
- R4: For a pair rotated at phase p quarter turns, the output pair (X, Y) is:
  - p = 0: (A, B)
  - p = 1: (−B, A)
  - p = 2: (−A, −B)
  - p = 3: (B, −A)
- R5: With `lower_sb` = 1, the phase step is negated modulo 4.
- R6: The phase is 0 for the first pair after reset and advances by the step after each pair. When `freq_sel` or `lower_sb` in the cycle a pair is rotated differs from its value in the previous cycle, that pair uses phase 0 and the count restarts from there.
- R7: With `freq_sel` = 0 and zero offsets, `out_a` and `out_b` equal the A and B input words.
- R8: `ofs_a` is added, as a signed two's-complement value, to path A after rotation, and `ofs_b` is added to path B in the same way.
- R9: Each output saturates to the range −32768..32767 instead of wrapping. This includes negating −32768, which gives 32767.
- R10: During and right after reset, `out_valid`, `out_a` and `out_b` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 16 | Interleaved A/B sample, two's complement |
| freq_sel | input | 2 | Coarse frequency code |
| lower_sb | input | 1 | 1 selects lower sideband (reverses rotation) |
| ofs_a | input | 16 | Signed offset for path A |
| ofs_b | input | 16 | Signed offset for path B |
| out_valid | output | 1 | Output pair qualifier |
| out_a | output | 16 | Path A result |
| out_b | output | 16 | Path B result |

## Verification
The critical coincidence is a change of frequency or sideband in the very cycle a completed pair enters the rotator. In that cycle, the phase reset and the phase advance compete for the same register. The bench provokes this by switching `freq_sel` and `lower_sb` right after the B word of a pair, so the new mode lands on the rotation cycle. It also switches them between pairs, and on the cycle a lone A word is taken. A behavioural model compares both paths on every clock, and it expects that pair at phase 0 and the next pair at one step.

// File: rtl/mix_pkg.sv
package mix_pkg;
    typedef enum logic [1:0] {
        FRQ_ZERO = 2'd0,
        FRQ_PQTR = 2'd1,
        FRQ_HALF = 2'd2,
        FRQ_NQTR = 2'd3
    } frq_e;

    typedef enum logic {
        ST_TAKE_I,
        ST_TAKE_Q
    } dil_st_e;

    typedef enum logic [1:0] {
        PH_0   = 2'd0,
        PH_90  = 2'd1,
        PH_180 = 2'd2,
        PH_270 = 2'd3
    } ph_e;

    function automatic logic [1:0] frq_step(input frq_e f, input logic lsb);
        logic [1:0] s;
        unique case (f)
            FRQ_ZERO: s = 2'd0;
            FRQ_PQTR: s = 2'd1;
            FRQ_HALF: s = 2'd2;
            FRQ_NQTR: s = 2'd3;
        endcase
        return lsb ? (2'd0 - s) : s;
    endfunction
endpackage

// File: rtl/mix_deint.sv
module mix_deint
    import mix_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         pair_v,
    output logic [W-1:0] pair_a,
    output logic [W-1:0] pair_b
);
    dil_st_e     st_q, st_d;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_TAKE_I;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_TAKE_I: if (in_valid) st_d = ST_TAKE_Q;
            ST_TAKE_Q: if (in_valid) st_d = ST_TAKE_I;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            pair_v <= 1'b0;
            pair_a <= '0;
            pair_b <= '0;
        end else begin
            pair_v <= 1'b0;
            if (in_valid) begin
                unique case (st_q)
                    ST_TAKE_I: hold_q <= in_data;
                    ST_TAKE_Q: begin
                        pair_a <= hold_q;
                        pair_b <= in_data;
                        pair_v <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R1
    pair_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_v |=> !pair_v);
endmodule

// File: rtl/mix_rot.sv
module mix_rot
    import mix_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pair_v,
    input  logic [W-1:0]     pair_a,
    input  logic [W-1:0]     pair_b,
    input  logic [1:0]       freq_sel,
    input  logic             lower_sb,
    output logic signed [W:0] rot_a,
    output logic signed [W:0] rot_b
);
    localparam int MODE_W = 3;

    ph_e               ph_q, ph_use, ph_d;
    logic [MODE_W-1:0] mode_q, mode_now;
    logic              chg;
    logic [1:0]        step;
    logic signed [W:0] ea, eb;

    assign mode_now = {freq_sel, lower_sb};
    assign chg      = (mode_now != mode_q);
    assign step     = frq_step(frq_e'(freq_sel), lower_sb);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_0;
            mode_q <= '0;
        end else begin
            ph_q   <= ph_d;
            mode_q <= mode_now;
        end
    end

    always_comb begin
        ph_use = chg ? PH_0 : ph_q;
        ph_d   = pair_v ? ph_e'(ph_use + step) : ph_use;
    end

    assign ea = {pair_a[W-1], pair_a};
    assign eb = {pair_b[W-1], pair_b};

    always_comb begin
        unique case (ph_use)
            PH_0:   begin rot_a = ea;  rot_b = eb;  end
            PH_90:  begin rot_a = -eb; rot_b = ea;  end
            PH_180: begin rot_a = -ea; rot_b = -eb; end
            PH_270: begin rot_a = eb;  rot_b = -ea; end
        endcase
    end

    // R6
    ph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_v && !chg) |=> $stable(ph_q));
endmodule

// File: rtl/mix_ofs.sv
module mix_ofs #(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_v,
    input  logic signed [W:0] in_x,
    input  logic [W-1:0]      ofs,
    output logic [W-1:0]      out
);
    logic signed [W+1:0] sum;
    logic                hi, lo;

    assign sum = {in_x[W], in_x} + {{2{ofs[W-1]}}, ofs};
    assign hi  = !sum[W+1] && (sum[W:W-1] != 2'b00);
    assign lo  =  sum[W+1] && (sum[W:W-1] != 2'b11);

    always_ff @(posedge clk) begin
        if (!rst_n) out <= '0;
        else if (in_v) begin
            if (hi)      out <= {1'b0, {(W-1){1'b1}}};
            else if (lo) out <= {1'b1, {(W-1){1'b0}}};
            else         out <= sum[W-1:0];
        end
    end

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_v && !in_x[W] && !ofs[W-1]) |=> !out[W-1]);
endmodule

// File: rtl/cplx_mixer_ofs.sv
module cplx_mixer_ofs
    import mix_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic [1:0]   freq_sel,
    input  logic         lower_sb,
    input  logic [W-1:0] ofs_a,
    input  logic [W-1:0] ofs_b,
    output logic         out_valid,
    output logic [W-1:0] out_a,
    output logic [W-1:0] out_b
);
    localparam int LANES = 2;

    logic              pv;
    logic [W-1:0]      pa, pb;
    logic signed [W:0] rot [LANES];
    logic [W-1:0]      ofs [LANES];
    logic [W-1:0]      res [LANES];

    mix_deint #(.W(W)) u_deint (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .pair_v(pv), .pair_a(pa), .pair_b(pb)
    );

    mix_rot #(.W(W)) u_rot (
        .clk(clk), .rst_n(rst_n), .pair_v(pv), .pair_a(pa), .pair_b(pb),
        .freq_sel(freq_sel), .lower_sb(lower_sb),
        .rot_a(rot[0]), .rot_b(rot[1])
    );

    assign ofs[0] = ofs_a;
    assign ofs[1] = ofs_b;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mix_ofs #(.W(W)) u_ofs (
            .clk(clk), .rst_n(rst_n), .in_v(pv),
            .in_x(rot[g]), .ofs(ofs[g]), .out(res[g])
        );
    end

    assign out_a = res[0];
    assign out_b = res[1];

    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= pv;
    end

    // R2
    lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pv));

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && freq_sel == FRQ_ZERO && ofs_a == '0 && ofs_b == '0)
        |=> (out_a == $past(pa) && out_b == $past(pb)));

    // R10
    rst_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_a == '0 && out_b == '0));
endmodule

// File: tb/cplx_mixer_ofs_tb.sv
module cplx_mixer_ofs_tb;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_data;
    logic [1:0]  freq_sel;
    logic        lower_sb;
    logic [15:0] ofs_a, ofs_b;
    logic        out_valid;
    logic [15:0] out_a, out_b;

    int    nchk = 0, nbad = 0;
    bit    done = 0;
    string tag  = "R10";

    // reference model state
    int m_wantq = 0, m_hold = 0, m_pv = 0, m_pa = 0, m_pb = 0;
    int m_mode_prev = 0, m_acc = 0, m_ev = 0, m_ea = 0, m_eb = 0;

    cplx_mixer_ofs u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .freq_sel(freq_sel), .lower_sb(lower_sb), .ofs_a(ofs_a), .ofs_b(ofs_b),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic int sat16(int x);
        if (x > 32767)  return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic int step_of(int f, int s);
        int b;
        b = f;   // R3: code 1 -> 1, 2 -> 2, 3 -> 3 quarter turns, 0 -> none
        if (s != 0) b = (4 - b) % 4;   // R5
        return b;
    endfunction

    task automatic check(string t, int act, int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic model_edge();
        int mode, chg, ph, x, y;
        mode = freq_sel * 2 + lower_sb;
        chg  = (mode != m_mode_prev);
        ph   = chg ? 0 : m_acc;
        if (m_pv != 0) begin
            case (ph)   // R4
                0: begin x = m_pa;  y = m_pb;  end
                1: begin x = -m_pb; y = m_pa;  end
                2: begin x = -m_pa; y = -m_pb; end
                default: begin x = m_pb; y = -m_pa; end
            endcase
            m_ea  = sat16(x + $signed(ofs_a));   // R8, R9
            m_eb  = sat16(y + $signed(ofs_b));
            m_ev  = 1;
            m_acc = (ph + step_of(freq_sel, lower_sb)) % 4;
        end else begin
            m_ev  = 0;
            m_acc = ph;
        end
        m_mode_prev = mode;
        m_pv = 0;
        if (in_valid) begin
            if (m_wantq == 0) begin
                m_hold  = $signed(in_data);
                m_wantq = 1;
            end else begin
                m_pa    = m_hold;
                m_pb    = $signed(in_data);
                m_pv    = 1;
                m_wantq = 0;
            end
        end
    endtask

    task automatic tick(bit v, int d);
        in_valid = v;
        in_data  = d[15:0];
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({tag, " valid"}, int'(out_valid), m_ev);
        if (m_ev != 0) begin
            check({tag, " path A"}, $signed(out_a), m_ea);
            check({tag, " path B"}, $signed(out_b), m_eb);
        end
    endtask

    task automatic pair(int a, int b);
        tick(1, a);
        tick(1, b);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PER * 100000);
        nchk++;
        nbad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        freq_sel = 2'd0;
        lower_sb = 1'b0;
        ofs_a    = '0;
        ofs_b    = '0;
        repeat (3) @(negedge clk);

        // R10: reset state
        check("R10 valid", int'(out_valid), 0);
        check("R10 out_a", int'(out_a), 0);
        check("R10 out_b", int'(out_b), 0);
        rst_n = 1'b1;

        // R7: bypass passes pairs unrotated
        tag = "R7";
        pair(100, -200);
        pair(32767, -32768);
        pair(-5, 7);
        tick(0, 0);
        tick(0, 0);

        // R1: idle cycles inside a pair are ignored
        tag = "R1";
        tick(1, 11);
        tick(0, 999);
        tick(0, 888);
        tick(1, 22);
        tick(0, 777);
        tick(1, 33);
        tick(1, 44);
        tick(0, 0);
        tick(0, 0);

        // R3 / R4: each coarse frequency, upper sideband
        for (int f = 1; f < 4; f++) begin
            tag = "R4";
            freq_sel = f[1:0];
            for (int k = 0; k < 5; k++) pair(1000 + k, -300 - k);
            tick(0, 0);
            tag = "R3";
            tick(0, 0);
        end

        // R5: lower sideband
        tag = "R5";
        lower_sb = 1'b1;
        for (int f = 1; f < 4; f++) begin
            freq_sel = f[1:0];
            for (int k = 0; k < 5; k++) pair(-400 + k, 250 + k);
        end
        tick(0, 0);
        tick(0, 0);

        // R6: mode change coinciding with the rotation cycle of a pair
        tag = "R6";
        lower_sb = 1'b0;
        freq_sel = 2'd1;
        pair(10, 20);
        pair(30, 40);
        freq_sel = 2'd3;        // lands on rotation of the second pair
        pair(50, 60);
        lower_sb = 1'b1;        // lands on rotation again
        pair(70, 80);
        tick(1, 90);
        freq_sel = 2'd2;        // change while only an A word is held
        tick(1, 100);
        pair(110, 120);
        tick(0, 0);
        freq_sel = 2'd1;        // change between pairs
        tick(0, 0);
        pair(130, 140);
        pair(150, 160);
        tick(0, 0);
        tick(0, 0);

        // R8: signed offsets per path
        tag = "R8";
        lower_sb = 1'b0;
        ofs_a = 16'sd123;
        ofs_b = -16'sd77;
        freq_sel = 2'd0;
        pair(1, 2);
        pair(-1000, 500);
        freq_sel = 2'd1;
        pair(300, -300);
        pair(5, 6);
        tick(0, 0);
        tick(0, 0);

        // R9: saturation on both rails and negation of the most negative word
        tag = "R9";
        freq_sel = 2'd0;
        ofs_a = 16'sd1000;
        ofs_b = -16'sd1000;
        pair(32700, -32700);
        ofs_a = 16'h8000;
        ofs_b = 16'h7fff;
        pair(-1, 1);
        ofs_a = '0;
        ofs_b = '0;
        freq_sel = 2'd2;
        pair(-32768, -32768);
        pair(-32768, 32767);
        tick(0, 0);
        tick(0, 0);

        // R2: single pulse per pair, nothing while idle
        tag = "R2";
        repeat (4) tick(0, 0);
        pair(9, 8);
        repeat (3) tick(0, 0);

        finish_up();
    end
endmodule